// File: doc/BRIEF.md
# Dual-Slope Integrating Converter Sequencer

This block is the digital half of a dual-slope analog-to-digital converter. An external integrator, comparator and two-way analog switch do the analog work. The block decides which voltage the switch feeds to the integrator, holds the integrator at zero while idle, and counts clock cycles. A conversion first integrates the unknown input for a fixed window of one full pass of an n-bit counter. It then switches the integrator to the negative reference and counts until the comparator reports that the integrator output has come back through zero. That second count is the conversion code. The ideal code is 2^n times the input voltage divided by the reference voltage. It does not depend on the integrator's resistor, its capacitor or the clock period.

The same counter is used for both phases. The integrate window ends when the counter wraps from all ones to zero. On that edge a phase flip-flop flips and drives the switch select. The comparator output is asynchronous to the clock, so it passes through a two-stage synchronizer before the sequencer uses it. A de-integrate phase that reaches the top count without a comparator trip returns a saturated code and raises an overrange flag.

Top module: `dsadc_ctrl`

## Requirements
- R1: While rst_ni is low, and after it is released with no start, result_o, done_o, ovr_o and sel_ref_o are 0 and int_rst_o is 1.
- R2: A start_i pulse sampled in idle begins a conversion. int_rst_o drops on the following cycle, and sel_ref_o stays 0 with int_rst_o 0 for exactly 2^CNT_W cycles. During this window the unknown input is integrated.
- R3: After the input window, sel_ref_o is 1 (reference selected) for the whole de-integrate phase, and the count restarts from 0. sel_ref_o is never 1 while int_rst_o is 1.
- R4: The code counts the de-integrate edges at which the synchronized comparator is high. Let cmp_i be lowered after the m-th clock edge that follows the edge setting sel_ref_o. The code is then m+2, because of the two synchronizer stages. If cmp_i is already low when the reference is selected, the code is 0.
- R5: A conversion that produces code N keeps sel_ref_o at 1 for N+1 cycles, the last being the capture cycle. Together with the input window this gives 2^CNT_W + N + 1 active cycles.
- R6: done_o is a one-cycle pulse in the cycle the new code and ovr_o first appear. In that cycle int_rst_o is already 1 and sel_ref_o is 0, so the block is back in idle.
- R7: If the synchronized comparator is still high when the count reaches all ones in the de-integrate phase, the code saturates at 2^CNT_W-1 and ovr_o is 1.
- R8: A comparator trip captured exactly at the all-ones count gives code 2^CNT_W-1 with ovr_o 0. Any in-range conversion clears a previous overrange.
- R9: A start_i pulse during a conversion has no effect. The input window still lasts 2^CNT_W cycles, the code is unchanged, and no second conversion follows.
- R10: result_o and ovr_o hold their values between done pulses. Comparator activity while idle does not change them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Conversion clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, sampled only in idle |
| cmp_i | input | 1 | Comparator output, high while integrator output is below zero |
| sel_ref_o | output | 1 | Switch select: 0 = unknown input, 1 = negative reference |
| int_rst_o | output | 1 | Integrator reset (held while idle) |
| result_o | output | CNT_W | Conversion code |
| done_o | output | 1 | One-cycle pulse when a new code is captured |
| ovr_o | output | 1 | Last conversion overranged |

## Verification
The bench moves the comparator fall across the de-integrate phase. A comparator that is low from the outset gives code 0. A fall right after the reference switch shows the two-cycle synchronizer offset. A mid-scale fall confirms linear counting. A fall landing exactly on the top count separates a legal full-scale code from overrange, and a comparator that never falls forces saturation. A stray start pulse inside the input window, followed by idle comparator toggling, shows that the window length and the stored code do not move.

// File: rtl/dsadc_pkg.sv
package dsadc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_INTEG = 2'd1,
    ST_DEINT = 2'd2
  } dsadc_state_e;
endpackage

// File: rtl/dsadc_sync.sv
module dsadc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ff_q <= '0;
    else         ff_q <= {ff_q[STAGES-2:0], d_i};
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/dsadc_counter.sv
module dsadc_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             phase_o,
  output logic             last_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;
  logic             phase_q;

  assign last_o = (cnt_q == CNT_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else if (en_i) begin
      cnt_q <= cnt_q + 1'b1;  // natural wrap ends the input window
      if (last_o && !phase_q) phase_q <= ~phase_q;
    end
  end

  assign cnt_o   = cnt_q;
  assign phase_o = phase_q;
endmodule

// File: rtl/dsadc_seq.sv
module dsadc_seq
  import dsadc_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             cmp_s_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             last_i,
  output logic             clr_o,
  output logic             en_o,
  output logic             int_rst_o,
  output logic [CNT_W-1:0] result_o,
  output logic             done_o,
  output logic             ovr_o
);
  dsadc_state_e state_q, state_d;
  logic [CNT_W-1:0] result_q;
  logic             done_q, ovr_q;
  logic             finish;

  // de-integrate ends on comparator trip or at the top count
  assign finish = (state_q == ST_DEINT) && (!cmp_s_i || last_i);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start_i) state_d = ST_INTEG;
      ST_INTEG: if (last_i)  state_d = ST_DEINT;
      ST_DEINT: if (finish)  state_d = ST_IDLE;
      default:               state_d = ST_IDLE;
    endcase
  end

  assign clr_o     = (state_q == ST_IDLE) || finish;
  assign en_o      = (state_q == ST_INTEG) || ((state_q == ST_DEINT) && !finish);
  assign int_rst_o = (state_q == ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      result_q <= '0;
      done_q   <= 1'b0;
      ovr_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= finish;
      if (finish) begin
        result_q <= cnt_i;
        ovr_q    <= cmp_s_i;  // still high at top count = overrange
      end
    end
  end

  assign result_o = result_q;
  assign done_o   = done_q;
  assign ovr_o    = ovr_q;
endmodule

// File: rtl/dsadc_ctrl.sv
module dsadc_ctrl #(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             cmp_i,
  output logic             sel_ref_o,
  output logic             int_rst_o,
  output logic [CNT_W-1:0] result_o,
  output logic             done_o,
  output logic             ovr_o
);
  logic             cmp_s;
  logic             cnt_clr, cnt_en, cnt_last, phase;
  logic [CNT_W-1:0] cnt;

  dsadc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (cmp_i),
    .q_o    (cmp_s)
  );

  dsadc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (cnt_clr),
    .en_i    (cnt_en),
    .cnt_o   (cnt),
    .phase_o (phase),
    .last_o  (cnt_last)
  );

  dsadc_seq #(.CNT_W(CNT_W)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .cmp_s_i   (cmp_s),
    .cnt_i     (cnt),
    .last_i    (cnt_last),
    .clr_o     (cnt_clr),
    .en_o      (cnt_en),
    .int_rst_o (int_rst_o),
    .result_o  (result_o),
    .done_o    (done_o),
    .ovr_o     (ovr_o)
  );

  assign sel_ref_o = phase;
endmodule

// File: rtl/dsadc_ctrl_chk.sv
module dsadc_ctrl_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sel_ref_o,
  input logic             int_rst_o,
  input logic [CNT_W-1:0] result_o,
  input logic             done_o,
  input logic             ovr_o
);
  assert_start_on_input_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(int_rst_o) |-> !sel_ref_o);

  assert_ref_not_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_ref_o |-> !int_rst_o);

  assert_ref_after_input_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sel_ref_o) |-> !$past(int_rst_o));

  assert_done_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (int_rst_o && !sel_ref_o));

  assert_ovr_saturates_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && ovr_o) |-> (result_o == {CNT_W{1'b1}}));

  assert_result_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(result_o) && $stable(ovr_o)));
endmodule

bind dsadc_ctrl dsadc_ctrl_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/dsadc_ctrl_test.sv
module dsadc_ctrl_test;
  localparam int CNT_W = 8;
  localparam int FULL  = 1 << CNT_W;
  localparam int MAXC  = FULL - 1;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             start_i = 1'b0;
  logic             cmp_i = 1'b0;
  logic             sel_ref_o, int_rst_o, done_o, ovr_o;
  logic [CNT_W-1:0] result_o;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  dsadc_ctrl #(.CNT_W(CNT_W)) uut (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .cmp_i     (cmp_i),
    .sel_ref_o (sel_ref_o),
    .int_rst_o (int_rst_o),
    .result_o  (result_o),
    .done_o    (done_o),
    .ovr_o     (ovr_o)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // m < 0: comparator low before the reference phase; never_fall: stays high
  task automatic convert(input int m, input bit never_fall, input bit extra_start,
                         output int integ, output int refc, output int res,
                         output int ovr, output int idle_at_done, output int done_after);
    int k;
    cmp_i   = (m >= 0) || never_fall;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    integ = 0;
    while (!sel_ref_o) begin
      if (!int_rst_o) integ++;
      start_i = extra_start && (integ == 10);
      @(negedge clk);
    end
    start_i = 1'b0;
    refc = 0;
    k = 0;
    while (!done_o) begin
      if (sel_ref_o) refc++;
      if (!never_fall && m >= 0 && k == m) cmp_i = 1'b0;
      k++;
      @(negedge clk);
    end
    res          = int'(result_o);
    ovr          = int'(ovr_o);
    idle_at_done = int'(int_rst_o && !sel_ref_o);
    @(negedge clk);
    done_after = int'(done_o);
  endtask

  task automatic t_reset();
    chk("R1", "result in reset", int'(result_o), 0);
    chk("R1", "done in reset", int'(done_o), 0);
    chk("R1", "ovr in reset", int'(ovr_o), 0);
    chk("R1", "sel_ref in reset", int'(sel_ref_o), 0);
    chk("R1", "int_rst in reset", int'(int_rst_o), 1);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", "int_rst idle after reset", int'(int_rst_o), 1);
    chk("R1", "sel_ref idle after reset", int'(sel_ref_o), 0);
  endtask

  task automatic t_conv(input string tag, input int m, input bit never_fall,
                        input bit extra_start, input int exp_n, input int exp_ovr);
    int integ, refc, res, ovr, idle, dafter;
    convert(m, never_fall, extra_start, integ, refc, res, ovr, idle, dafter);
    chk("R2", {tag, " input window cycles"}, integ, FULL);
    chk("R4", {tag, " code"}, res, exp_n);
    chk("R5", {tag, " reference cycles"}, refc, exp_n + 1);
    chk("R6", {tag, " idle at done"}, idle, 1);
    chk("R6", {tag, " done one cycle"}, dafter, 0);
    if (exp_ovr) chk("R7", {tag, " overrange flag"}, ovr, 1);
    else         chk("R8", {tag, " overrange flag"}, ovr, 0);
  endtask

  task automatic t_start_ignored();
    t_conv("R9 stray start", 20, 1'b0, 1'b1, 22, 0);
    repeat (20) @(negedge clk);
    chk("R9", "no second conversion", int'(int_rst_o), 1);
    chk("R9", "code kept", int'(result_o), 22);
  endtask

  task automatic t_hold();
    for (int i = 0; i < 12; i++) begin
      cmp_i = i[0];
      @(negedge clk);
    end
    chk("R10", "code held in idle", int'(result_o), 22);
    chk("R10", "ovr held in idle", int'(ovr_o), 0);
    chk("R10", "no done in idle", int'(done_o), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_conv("R4 zero input", -1, 1'b0, 1'b0, 0, 0);
    t_conv("R4 early trip", 0, 1'b0, 1'b0, 2, 0);
    t_conv("R4 mid scale", 100, 1'b0, 1'b0, 102, 0);
    t_conv("R8 full scale", MAXC - 2, 1'b0, 1'b0, MAXC, 0);
    t_conv("R7 overrange", 0, 1'b1, 1'b0, MAXC, 1);
    t_conv("R8 clears ovr", 5, 1'b0, 1'b0, 7, 0);
    t_start_ignored();
    t_hold();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule